// File: doc/BRIEF.md
# Programmable DRAM Command Sequencer

This block runs software-written programs of DRAM commands. A host sends a stream of 64-bit instruction words. The block collects them in an instruction queue and, once a program is complete, issues them one by one on a DDR-style command port. It keeps to the exact order in which the words arrived.

The block applies no DRAM timing rules of its own. The only spacing between two commands comes from WAIT instructions placed between them. This lets a test program shorten latencies below their datasheet values on purpose.

Read data that comes back from the memory side is registered and passed to the host. A single-cycle completion pulse marks the end of each program. A sticky flag records any instruction word whose opcode is not defined.

A program is released for execution only after its terminating END word has been queued. A whole program, END included, has to fit in the queue (`DEPTH` entries; a WRITE and its data word together take one entry).

Top module: `dram_cmd_seq`

## Requirements
- R1: After reset, `cmd_valid`, `done`, `err` and `host_rd_valid` are low and `in_ready` is high.
- R2: Each instruction word has these fields:
  - Opcode in bits [63:60]: 1 = ACTIVATE, 2 = READ, 3 = WRITE, 4 = PRECHARGE, 5 = WAIT, 6 = END.
  - Bank in bits [34:32].
  - Row or column in bits [15:0].
  - WAIT count in bits [31:0].
  - A WRITE word is followed by one data word.
  - Commands appear on `cmd_op` as 0 = ACTIVATE, 1 = READ, 2 = WRITE, 3 = PRECHARGE, with `cmd_bank` and `cmd_addr` taken from the instruction.
- R3: No command is issued from queued instructions until an END word has been accepted.
- R4: Commands are issued in the order their instructions were accepted. Each ACTIVATE, READ, WRITE or PRECHARGE produces exactly one command, with `cmd_valid` high for one cycle.
- R5: Command spacing within a program:
  - Two commands with no instruction between them are issued on consecutive cycles.
  - A WAIT of N ≥ 1 between two commands adds exactly N cycles with no command.
  - A WAIT of 0 adds one such cycle.
- R6: A WRITE command carries the data word that followed its instruction on `cmd_wdata`.
- R7: Each `rd_valid` beat appears on `host_rd_valid`/`host_rd_data` one cycle later, with the same data and in the same order.
- R8: `done` pulses high for one cycle, one cycle after the last command of a program, when no WAIT comes before END. The next program does not start before that pulse.
- R9: An undefined opcode produces no command, takes one instruction slot, and sets `err`, which then stays high until reset.
- R10: `in_ready` is low while the queue holds `DEPTH` entries. Words accepted while a program runs are not executed until that program's END has been executed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Host word valid |
| in_word | input | 64 | Host instruction or write-data word |
| in_ready | output | 1 | Block can accept a host word |
| cmd_valid | output | 1 | DRAM command strobe |
| cmd_op | output | 2 | DRAM command code |
| cmd_bank | output | BANK_W | Bank of the command |
| cmd_addr | output | ROW_W | Row (ACTIVATE) or column (READ/WRITE) |
| cmd_wdata | output | 64 | Write data of a WRITE command |
| rd_valid | input | 1 | Read data beat from memory side |
| rd_data | input | 64 | Read data from memory side |
| host_rd_valid | output | 1 | Read data valid toward host |
| host_rd_data | output | 64 | Read data toward host |
| done | output | 1 | One-cycle pulse when a program's END executes |
| err | output | 1 | Sticky undefined-opcode flag |

## Verification
The hardest state to reach from the ports is a full queue while a program is still executing. Only in that state does backpressure coincide with words that must be held back.

The bench reaches it with a first program made of a long WAIT and an END. While the dispatcher stalls on that WAIT, the bench streams in a second program's commands without its END. This fills the queue, and the bench observes `in_ready` low with no stray commands.

The bench then offers the second END. That word can only be accepted after the first END has drained. The bench confirms that the second program starts only after the first `done` pulse.

// File: rtl/seq_pkg.sv
// Shared definitions for the DRAM command sequencer: word layout, opcodes
// and the command codes driven toward the DRAM side.
package seq_pkg;
    localparam int WORD_W    = 64;
    localparam int OPC_LSB   = 60;
    localparam int BANK_LSB  = 32;

    typedef enum logic [3:0] {
        OPC_ACT  = 4'd1,
        OPC_RD   = 4'd2,
        OPC_WR   = 4'd3,
        OPC_PRE  = 4'd4,
        OPC_WAIT = 4'd5,
        OPC_END  = 4'd6
    } opcode_e;

    typedef enum logic [1:0] {
        DC_ACT = 2'd0,
        DC_RD  = 2'd1,
        DC_WR  = 2'd2,
        DC_PRE = 2'd3
    } dcmd_e;

    typedef struct packed {
        logic [WORD_W-1:0] instr;
        logic [WORD_W-1:0] wdata;
    } qentry_t;
endpackage

// File: rtl/instr_rx.sv
// Instruction receiver. Takes host words, pairs a WRITE instruction with the
// data word that follows it, and pushes complete entries into the queue.
// Assumes the host always sends the data word directly after a WRITE.
module instr_rx
    import seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              in_ready,
    input  logic              q_full,
    output logic              push,
    output qentry_t           push_entry,
    output logic              push_end
);
    logic              wr_pending;
    logic [WORD_W-1:0] wr_instr;
    logic              take;

    assign in_ready = !q_full;
    assign take     = in_valid && in_ready;

    // Decide whether the accepted word completes an entry.
    always_comb begin
        push             = 1'b0;
        push_entry.instr = in_word;
        push_entry.wdata = '0;
        if (take) begin
            if (wr_pending) begin
                push             = 1'b1;
                push_entry.instr = wr_instr;
                push_entry.wdata = in_word;
            end else if (in_word[WORD_W-1:OPC_LSB] != OPC_WR) begin
                push = 1'b1;
            end
        end
    end

    assign push_end = push && (push_entry.instr[WORD_W-1:OPC_LSB] == OPC_END);

    // Hold a WRITE instruction until its data word arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_pending <= 1'b0;
            wr_instr   <= '0;
        end else if (take) begin
            if (wr_pending) begin
                wr_pending <= 1'b0;
            end else if (in_word[WORD_W-1:OPC_LSB] == OPC_WR) begin
                wr_pending <= 1'b1;
                wr_instr   <= in_word;
            end
        end
    end
endmodule

// File: rtl/instr_fifo.sv
// Instruction queue: show-ahead FIFO of DEPTH entries of width W.
// Assumes the producer never pushes when full and the consumer never pops
// when empty; both are checked below.
module instr_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] count;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy tracking with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            count <= count + CW'(push) - CW'(pop);
        end
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
endmodule

// File: rtl/seq_dispatch.sv
// Dispatcher. Waits until a complete program (END queued) is present, then
// consumes queue entries one per cycle, issuing one registered DRAM command
// per access instruction and stalling on WAIT. No DRAM timing is enforced.
module seq_dispatch
    import seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  qentry_t           head,
    input  logic              q_empty,
    input  logic              end_pushed,
    output logic              pop,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic [WORD_W-1:0] cmd_wdata,
    output logic              done,
    output logic              err
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} dstate_e;

    dstate_e           state;
    logic [CW-1:0]     ends_queued;
    logic [WAIT_W-1:0] hold_cnt;
    logic [3:0]        opc;
    logic [WAIT_W-1:0] wait_len;
    logic              end_pop;

    assign opc      = head.instr[WORD_W-1:OPC_LSB];
    assign wait_len = head.instr[WAIT_W-1:0];
    assign pop      = (state == ST_RUN) && !q_empty;
    assign end_pop  = pop && (opc == OPC_END);

    // Count complete programs waiting in the queue.
    always_ff @(posedge clk) begin
        if (!rst_n) ends_queued <= '0;
        else        ends_queued <= ends_queued + CW'(end_pushed) - CW'(end_pop);
    end

    // Main sequencing: decode the head entry and drive the command port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            hold_cnt  <= '0;
            cmd_valid <= 1'b0;
            cmd_op    <= DC_ACT;
            cmd_bank  <= '0;
            cmd_addr  <= '0;
            cmd_wdata <= '0;
            done      <= 1'b0;
            err       <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            done      <= 1'b0;
            case (state)
                ST_IDLE: if (ends_queued != '0) state <= ST_RUN;
                ST_RUN: if (pop) begin
                    cmd_bank  <= head.instr[BANK_LSB +: BANK_W];
                    cmd_addr  <= head.instr[ROW_W-1:0];
                    cmd_wdata <= '0;
                    case (opc)
                        OPC_ACT: begin cmd_valid <= 1'b1; cmd_op <= DC_ACT; end
                        OPC_RD:  begin cmd_valid <= 1'b1; cmd_op <= DC_RD;  end
                        OPC_WR: begin
                            cmd_valid <= 1'b1;
                            cmd_op    <= DC_WR;
                            cmd_wdata <= head.wdata;
                        end
                        OPC_PRE: begin cmd_valid <= 1'b1; cmd_op <= DC_PRE; end
                        OPC_WAIT: if (wait_len > WAIT_W'(1)) begin
                            hold_cnt <= wait_len - 1'b1;
                            state    <= ST_HOLD;
                        end
                        OPC_END: begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end
                        default: err <= 1'b1;
                    endcase
                end
                ST_HOLD: begin
                    hold_cnt <= hold_cnt - 1'b1;
                    if (hold_cnt == WAIT_W'(1)) state <= ST_RUN;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    end_counted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_pop |-> (ends_queued != '0));
    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    // R5
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |=> !cmd_valid);
endmodule

// File: rtl/rd_return.sv
// Read-data return path: registers each beat from the memory side and
// presents it to the host one cycle later, in arrival order.
module rd_return #(
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_valid,
    input  logic [DW-1:0] rd_data,
    output logic          host_rd_valid,
    output logic [DW-1:0] host_rd_data
);
    // Capture register toward the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rd_valid <= 1'b0;
            host_rd_data  <= '0;
        end else begin
            host_rd_valid <= rd_valid;
            if (rd_valid) host_rd_data <= rd_data;
        end
    end

    // R7
    rd_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> (host_rd_valid && host_rd_data == $past(rd_data)));
endmodule

// File: rtl/dram_cmd_seq.sv
// Top of the programmable DRAM command sequencer: receiver, instruction
// queue, dispatcher and read-data return. Assumes one program (END
// included) fits in DEPTH queue entries.
module dram_cmd_seq
    import seq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int BANK_W = 3,
    parameter int ROW_W  = 16,
    parameter int WAIT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       in_word,
    output logic              in_ready,
    output logic              cmd_valid,
    output logic [1:0]        cmd_op,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ROW_W-1:0]  cmd_addr,
    output logic [63:0]       cmd_wdata,
    input  logic              rd_valid,
    input  logic [63:0]       rd_data,
    output logic              host_rd_valid,
    output logic [63:0]       host_rd_data,
    output logic              done,
    output logic              err
);
    localparam int QW = $bits(qentry_t);

    logic    q_full, q_empty, push, push_end, pop;
    qentry_t push_entry, head;

    instr_rx u_rx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .q_full(q_full), .push(push),
        .push_entry(push_entry), .push_end(push_end)
    );

    instr_fifo #(.DEPTH(DEPTH), .W(QW)) u_q (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_entry),
        .pop(pop), .head(head), .full(q_full), .empty(q_empty)
    );

    seq_dispatch #(.DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .WAIT_W(WAIT_W)) u_disp (
        .clk(clk), .rst_n(rst_n), .head(head), .q_empty(q_empty),
        .end_pushed(push_end), .pop(pop), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .done(done), .err(err)
    );

    rd_return #(.DW(64)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
        .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data)
    );

    // R8
    done_vs_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && cmd_valid));
endmodule

// File: tb/tb_dram_cmd_seq.sv
module tb_dram_cmd_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic        in_ready;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [15:0] cmd_addr;
    logic [63:0] cmd_wdata;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic        host_rd_valid;
    logic [63:0] host_rd_data;
    logic        done, err;

    always #2.5 clk = ~clk;

    dram_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .in_ready(in_ready), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .host_rd_valid(host_rd_valid),
        .host_rd_data(host_rd_data), .done(done), .err(err)
    );

    int nchk = 0, nfail = 0, cyc = 0;
    int nlog = 0, nhr = 0, ndone = 0, last_done_cyc = 0;
    logic [1:0]  log_op   [0:255];
    logic [2:0]  log_bank [0:255];
    logic [15:0] log_addr [0:255];
    logic [63:0] log_wd   [0:255];
    int          log_cyc  [0:255];
    logic [63:0] hr_data  [0:255];
    logic [63:0] mem [0:7][0:15];
    logic        p0v = 0, p1v = 0;
    logic [63:0] p0d = '0, p1d = '0;

    // DRAM model, command logger and host-side monitor, all at the falling edge.
    always @(negedge clk) begin
        cyc = cyc + 1;
        rd_valid = p1v; rd_data = p1d;
        p1v = p0v; p1d = p0d; p0v = 1'b0;
        if (cmd_valid && nlog < 256) begin
            log_op[nlog] = cmd_op; log_bank[nlog] = cmd_bank;
            log_addr[nlog] = cmd_addr; log_wd[nlog] = cmd_wdata;
            log_cyc[nlog] = cyc; nlog = nlog + 1;
            if (cmd_op == 2'd2) mem[cmd_bank][cmd_addr[3:0]] = cmd_wdata;
            if (cmd_op == 2'd1) begin p0v = 1'b1; p0d = mem[cmd_bank][cmd_addr[3:0]]; end
        end
        if (host_rd_valid && nhr < 256) begin hr_data[nhr] = host_rd_data; nhr = nhr + 1; end
        if (done) begin ndone = ndone + 1; last_done_cyc = cyc; end
        if (cyc > 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk = nchk + 1;
        if (act !== exp) begin
            nfail = nfail + 1;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input int op, input int bank, input int addr);
        return {4'(op), 25'd0, 3'(bank), 16'd0, 16'(addr)};
    endfunction
    function automatic logic [63:0] mkw(input int n);
        return {4'd5, 28'd0, 32'(n)};
    endfunction

    task automatic send(input logic [63:0] w);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_word = w;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_done(input int target);
        for (int i = 0; i < 2000 && ndone < target; i++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic t_reset;
        check("R1 cmd_valid", cmd_valid, 0);
        check("R1 done", done, 0);
        check("R1 err", err, 0);
        check("R1 host_rd_valid", host_rd_valid, 0);
        check("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_hold_until_end;
        int b = nlog, d = ndone;
        send(mk(1, 1, 16'h0042));
        send(mkw(3));
        repeat (20) @(negedge clk);
        check("R3 no cmd before END", nlog - b, 0);
        send(mk(6, 0, 0));
        wait_done(d + 1);
        check("R3 cmd after END", nlog - b, 1);
        check("R2 act op", log_op[b], 0);
        check("R2 act bank", log_bank[b], 1);
        check("R2 act row", log_addr[b], 16'h0042);
        check("R8 one done", ndone - d, 1);
    endtask

    task automatic t_write_read;
        int b = nlog, h = nhr, d = ndone;
        send(mk(1, 2, 16'h1234));
        send(mkw(4));
        send(mk(3, 2, 5)); send(64'hDEAD_BEEF_0123_4567);
        send(mkw(0));
        send(mk(2, 2, 5));
        send(mkw(10));
        send(mk(4, 2, 0));
        send(mk(6, 0, 0));
        wait_done(d + 1);
        check("R4 count", nlog - b, 4);
        check("R4 order wr", log_op[b+1], 2);
        check("R4 order rd", log_op[b+2], 1);
        check("R4 order pre", log_op[b+3], 3);
        check("R5 wait4 gap", log_cyc[b+1] - log_cyc[b], 5);
        check("R5 wait0 gap", log_cyc[b+2] - log_cyc[b+1], 2);
        check("R5 wait10 gap", log_cyc[b+3] - log_cyc[b+2], 11);
        check("R6 wdata", log_wd[b+1], 64'hDEAD_BEEF_0123_4567);
        check("R2 wr col", log_addr[b+1], 5);
        check("R7 read count", nhr - h, 1);
        check("R7 read data", hr_data[h], 64'hDEAD_BEEF_0123_4567);
        check("R8 done after pre", last_done_cyc - log_cyc[b+3], 1);
    endtask

    task automatic t_back_to_back;
        int b = nlog, h = nhr, d = ndone;
        send(mk(3, 1, 3)); send(64'hAAAA_0000_0000_0003);
        send(mk(3, 1, 4)); send(64'hBBBB_0000_0000_0004);
        send(mk(2, 1, 3));
        send(mk(2, 1, 4));
        send(mk(4, 1, 0));
        send(mk(6, 0, 0));
        wait_done(d + 1);
        check("R4 b2b count", nlog - b, 5);
        for (int i = 1; i < 5; i++) check("R5 b2b gap", log_cyc[b+i] - log_cyc[b+i-1], 1);
        check("R7 b2b reads", nhr - h, 2);
        check("R7 first read", hr_data[h], 64'hAAAA_0000_0000_0003);
        check("R7 second read", hr_data[h+1], 64'hBBBB_0000_0000_0004);
        check("R8 done adjacent", last_done_cyc - log_cyc[b+4], 1);
    endtask

    task automatic t_bad_opcode;
        int b = nlog, d = ndone;
        check("R9 err clear before", err, 0);
        send(mk(1, 3, 7));
        send({4'hF, 60'd0});
        send(mk(4, 3, 0));
        send(mk(6, 0, 0));
        wait_done(d + 1);
        check("R9 cmd count", nlog - b, 2);
        check("R9 slot gap", log_cyc[b+1] - log_cyc[b], 2);
        check("R9 err set", err, 1);
        repeat (10) @(negedge clk);
        check("R9 err sticky", err, 1);
    endtask

    task automatic t_backpressure;
        int b, d = ndone;
        send(mkw(300));
        send(mk(6, 0, 0));
        repeat (5) @(negedge clk);
        b = nlog;
        for (int i = 0; i < 15; i++) send(mk(4, i % 8, 0));
        check("R10 ready low when full", in_ready, 0);
        check("R10 nothing issued", nlog - b, 0);
        check("R10 first batch pending", ndone - d, 0);
        send(mk(6, 0, 0));
        wait_done(d + 2);
        check("R10 both done", ndone - d, 2);
        check("R10 held cmds issued", nlog - b, 15);
        check("R10 after first done", (log_cyc[b] > last_done_cyc - 20) ? 1 : 0, 1);
        check("R4 order bank", log_bank[b+9], 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_hold_until_end;
        t_write_read;
        t_back_to_back;
        t_bad_opcode;
        t_backpressure;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end
endmodule